// File: doc/BRIEF.md
# Peripheral Bridge Access Protection Checker

This block stands between one bus master port and a group of peripheral slots and gates every access. A single 32-bit protection word holds a 4-bit field for each of eight slots. Each field can demand a trusted master, forbid writes, or demand supervisor privilege. A second, narrower register holds one privilege-enable bit per master. Each request names a slot, says whether it is a write, and carries a supervisor attribute, a trusted attribute and a master ID. The block weighs all three restrictions of the addressed slot at once.

One cycle after a request the block produces exactly one of two outcomes. In the first it forwards the access downstream with a one-cycle valid pulse carrying the slot index and write flag. In the second it returns a one-cycle error response, and no downstream access appears at all. Software reads and writes both registers through a simple select/write/data port. The unimplemented bit in each field always reads as zero.

Top module: `pbridge_guard`

## Requirements
- R1: After reset the protection word reads 0 (no restriction) and the privilege register reads all ones in its NUM_MASTERS low bits.
- R2: Slot s (0..7) owns bits [31-4s:28-4s] of the protection word. Within the field, bit 28-4s is trusted-protect, bit 29-4s is write-protect and bit 30-4s is supervisor-protect. A protection bit affects only requests to its own slot.
- R3: Bit 31-4s of each field is reserved: it reads 0 and writes to it are ignored. Privilege register bits at and above NUM_MASTERS read 0.
- R4: If write-protect is 1, a write to the slot ends in an error. A read to the same slot still passes.
- R5: If trusted-protect is 1, a request with req_trusted = 0 ends in an error. A request with req_trusted = 1 passes that check.
- R6: If supervisor-protect is 1, the request passes that check only when req_super = 1 and privilege bit req_mid is 1. Otherwise it ends in an error.
- R7: A protection bit of 0 disables its restriction. With an all-zero field, any request passes whatever its attributes.
- R8: For each request the block asserts exactly one of dn_valid or err_resp, for one cycle, in the cycle after the request. With no request it asserts neither. An erroring request never raises dn_valid.
- R9: When dn_valid is high, dn_slot and dn_write equal the slot and write flag of the request that produced it.
- R10: A register write takes effect for requests from the following cycle on. A request made in the same cycle as the write is judged against the old value.
- R11: Privilege bit m belongs to master ID m and can be read back as written. Register select 0 addresses the protection word; select 1 addresses the privilege register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register select: 0 protection word, 1 privilege register |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Access request present |
| req_slot | input | 3 | Target slot index |
| req_write | input | 1 | 1 for write, 0 for read |
| req_super | input | 1 | Supervisor attribute of the access |
| req_trusted | input | 1 | Trusted attribute of the requesting master |
| req_mid | input | 3 | Requesting master ID |
| dn_valid | output | 1 | One-cycle downstream access start |
| dn_slot | output | 3 | Slot index of the forwarded access |
| dn_write | output | 1 | Write flag of the forwarded access |
| err_resp | output | 1 | One-cycle error response |

## Verification
The bench builds the block at its default parameters: eight slots, eight masters and a 32-bit word. With these the highest field (bits 31:28) and the lowest field (bits 3:0) are both in play, and so is master ID 7 at the top of the privilege register. A walk of a single write-protect bit across all eight slots pins down the field positions, and every request is also sent to the neighbouring slot to show that the bit stays local. The directed cases cover the reserved-bit mask, the last-cycle effect of a register write landing together with a request, and the single-cycle width of both outcomes.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
   // Bit positions inside one slot field (LSB = 0).
   localparam int FIELD_W  = 4;
   localparam int TP_BIT   = 0;
   localparam int WP_BIT   = 1;
   localparam int SP_BIT   = 2;
   localparam int RSV_BIT  = 3;
   localparam int LIVE_W   = 3;

   typedef struct packed {
      logic sup;
      logic wrp;
      logic trp;
   } viol_t;
endpackage

// File: rtl/pbg_ctrl_regs.sv
module pbg_ctrl_regs
   import pbg_pkg::*;
#(
   parameter int NUM_SLOTS   = 8,
   parameter int NUM_MASTERS = 8,
   parameter int DATA_W      = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_sel,
   input  logic                   reg_wr,
   input  logic [DATA_W-1:0]      reg_wdata,
   output logic [DATA_W-1:0]      reg_rdata,
   output logic [DATA_W-1:0]      acr_q,
   output logic [NUM_MASTERS-1:0] priv_q
);
   localparam int USED_W = NUM_SLOTS * FIELD_W;

   logic [DATA_W-1:0] wmask;

   // Writable-bit mask: three live bits per field, reserved bit held at 0.
   genvar s;
   generate
      for (s = 0; s < NUM_SLOTS; s++) begin : g_mask
         localparam int BASE = DATA_W - FIELD_W * (s + 1);
         assign wmask[BASE +: LIVE_W]  = '1;
         assign wmask[BASE + RSV_BIT]  = 1'b0;
      end
      if (DATA_W > USED_W) begin : g_low_pad
         assign wmask[DATA_W-USED_W-1:0] = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acr_q  <= '0;
         priv_q <= '1;
      end else if (reg_wr) begin
         if (!reg_sel) acr_q  <= reg_wdata & wmask;
         else          priv_q <= reg_wdata[NUM_MASTERS-1:0];
      end
   end

   generate
      if (DATA_W > NUM_MASTERS) begin : g_priv_pad
         always_comb begin
            if (!reg_sel) reg_rdata = acr_q;
            else          reg_rdata = {{(DATA_W-NUM_MASTERS){1'b0}}, priv_q};
         end
      end else begin : g_priv_full
         always_comb begin
            if (!reg_sel) reg_rdata = acr_q;
            else          reg_rdata = priv_q;
         end
      end
   endgenerate
endmodule

// File: rtl/pbg_rule_check.sv
module pbg_rule_check
   import pbg_pkg::*;
#(
   parameter int NUM_SLOTS   = 8,
   parameter int NUM_MASTERS = 8,
   parameter int DATA_W      = 32,
   localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int MID_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
   input  logic [DATA_W-1:0]      acr,
   input  logic [NUM_MASTERS-1:0] priv,
   input  logic [SLOT_W-1:0]      slot,
   input  logic                   is_write,
   input  logic                   is_super,
   input  logic                   is_trusted,
   input  logic [MID_W-1:0]       mid,
   output viol_t                  why,
   output logic                   deny
);
   logic [LIVE_W-1:0] live [NUM_SLOTS];
   logic [LIVE_W-1:0] pick;
   logic              priv_ok;

   genvar s;
   generate
      for (s = 0; s < NUM_SLOTS; s++) begin : g_fields
         localparam int BASE = DATA_W - FIELD_W * (s + 1);
         assign live[s] = acr[BASE +: LIVE_W];
      end
   endgenerate

   always_comb begin
      pick    = live[slot];
      priv_ok = is_super & priv[mid];
      why.wrp = pick[WP_BIT] & is_write;
      why.trp = pick[TP_BIT] & ~is_trusted;
      why.sup = pick[SP_BIT] & ~priv_ok;
      deny    = |why;
   end
endmodule

// File: rtl/pbg_issue.sv
module pbg_issue #(
   parameter int SLOT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [SLOT_W-1:0] req_slot,
   input  logic              req_write,
   input  logic              deny,
   output logic              dn_valid,
   output logic [SLOT_W-1:0] dn_slot,
   output logic              dn_write,
   output logic              err_resp
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dn_valid <= 1'b0;
         err_resp <= 1'b0;
         dn_slot  <= '0;
         dn_write <= 1'b0;
      end else begin
         dn_valid <= req_valid & ~deny;
         err_resp <= req_valid & deny;
         if (req_valid) begin
            dn_slot  <= req_slot;
            dn_write <= req_write;
         end
      end
   end
endmodule

// File: rtl/pbridge_guard.sv
module pbridge_guard
   import pbg_pkg::*;
#(
   parameter int NUM_SLOTS   = 8,
   parameter int NUM_MASTERS = 8,
   parameter int DATA_W      = 32,
   localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int MID_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              req_valid,
   input  logic [SLOT_W-1:0] req_slot,
   input  logic              req_write,
   input  logic              req_super,
   input  logic              req_trusted,
   input  logic [MID_W-1:0]  req_mid,
   output logic              dn_valid,
   output logic [SLOT_W-1:0] dn_slot,
   output logic              dn_write,
   output logic              err_resp
);
   generate
      if (NUM_SLOTS * FIELD_W > DATA_W) begin : g_bad_width
         $error("slot fields do not fit in the protection word");
      end
      if (NUM_MASTERS > DATA_W) begin : g_bad_masters
         $error("privilege register wider than data bus");
      end
      if (NUM_SLOTS != (1 << SLOT_W)) begin : g_bad_slots
         $error("NUM_SLOTS must be a power of two");
      end
      if (NUM_MASTERS != (1 << MID_W)) begin : g_bad_mid
         $error("NUM_MASTERS must be a power of two");
      end
   endgenerate

   logic [DATA_W-1:0]      acr_q;
   logic [NUM_MASTERS-1:0] priv_q;
   viol_t                  why;
   logic                   deny;

   pbg_ctrl_regs #(
      .NUM_SLOTS(NUM_SLOTS), .NUM_MASTERS(NUM_MASTERS), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .acr_q(acr_q), .priv_q(priv_q)
   );

   pbg_rule_check #(
      .NUM_SLOTS(NUM_SLOTS), .NUM_MASTERS(NUM_MASTERS), .DATA_W(DATA_W)
   ) u_rule (
      .acr(acr_q), .priv(priv_q), .slot(req_slot), .is_write(req_write),
      .is_super(req_super), .is_trusted(req_trusted), .mid(req_mid),
      .why(why), .deny(deny)
   );

   pbg_issue #(.SLOT_W(SLOT_W)) u_issue (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slot(req_slot),
      .req_write(req_write), .deny(deny), .dn_valid(dn_valid),
      .dn_slot(dn_slot), .dn_write(dn_write), .err_resp(err_resp)
   );
endmodule

// File: rtl/pbg_checks.sv
module pbg_checks
   import pbg_pkg::*;
#(
   parameter int NUM_SLOTS   = 8,
   parameter int NUM_MASTERS = 8,
   parameter int DATA_W      = 32,
   localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
   localparam int MID_W      = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   reg_sel,
   input logic [DATA_W-1:0]      reg_rdata,
   input logic                   req_valid,
   input logic [SLOT_W-1:0]      req_slot,
   input logic                   req_write,
   input logic                   req_super,
   input logic                   req_trusted,
   input logic [MID_W-1:0]       req_mid,
   input logic                   dn_valid,
   input logic [SLOT_W-1:0]      dn_slot,
   input logic                   dn_write,
   input logic                   err_resp,
   input logic [DATA_W-1:0]      acr,
   input logic [NUM_MASTERS-1:0] priv
);
   logic [LIVE_W-1:0] nib;
   logic [DATA_W-1:0] rsv_bits;

   always_comb begin
      nib = LIVE_W'(acr >> (DATA_W - FIELD_W * (int'(req_slot) + 1)));
      rsv_bits = '0;
      for (int s = 0; s < NUM_SLOTS; s++)
         rsv_bits[DATA_W - FIELD_W * s - 1] = 1'b1;
   end

   // R8: exactly one outcome per request
   assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (dn_valid ^ err_resp));
   // R8: quiet without request
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!dn_valid && !err_resp));
   // R4
   assert_wp_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && nib[WP_BIT]) |=> err_resp);
   // R5
   assert_tp_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_trusted && nib[TP_BIT]) |=> err_resp);
   // R6
   assert_sp_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && nib[SP_BIT] && !(req_super && priv[req_mid])) |=> err_resp);
   // R7
   assert_open_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && nib == '0) |=> dn_valid);
   // R9
   assert_echo_R9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (dn_slot == $past(req_slot) && dn_write == $past(req_write)));
   // R3
   assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> ((reg_rdata & rsv_bits) == '0));
endmodule

bind pbridge_guard pbg_checks #(
   .NUM_SLOTS(NUM_SLOTS), .NUM_MASTERS(NUM_MASTERS), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_rdata(reg_rdata),
   .req_valid(req_valid), .req_slot(req_slot), .req_write(req_write),
   .req_super(req_super), .req_trusted(req_trusted), .req_mid(req_mid),
   .dn_valid(dn_valid), .dn_slot(dn_slot), .dn_write(dn_write),
   .err_resp(err_resp), .acr(acr_q), .priv(priv_q)
);

// File: tb/pbridge_guard_bench.sv
module pbridge_guard_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0, reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0, req_trusted = 1'b0;
   logic [2:0]  req_slot = '0, req_mid = '0;
   logic        dn_valid, dn_write, err_resp;
   logic [2:0]  dn_slot;

   int tests = 0, fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pbridge_guard u_pbridge_guard (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
      .req_slot(req_slot), .req_write(req_write), .req_super(req_super),
      .req_trusted(req_trusted), .req_mid(req_mid), .dn_valid(dn_valid),
      .dn_slot(dn_slot), .dn_write(dn_write), .err_resp(err_resp)
   );

   typedef struct packed {
      logic [31:0] acr;
      logic [7:0]  priv;
      logic [2:0]  slot;
      logic        wr;
      logic        sup;
      logic        tru;
      logic [2:0]  mid;
      logic        exp_err;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_0000, 8'hFF, 3'd3, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 4'd7}, // R7 open slot
      '{32'h2000_0000, 8'hFF, 3'd0, 1'b1, 1'b0, 1'b1, 3'd0, 1'b1, 4'd4}, // R4 write blocked
      '{32'h2000_0000, 8'hFF, 3'd0, 1'b0, 1'b0, 1'b1, 3'd0, 1'b0, 4'd4}, // R4 read allowed
      '{32'h0000_0001, 8'hFF, 3'd7, 1'b0, 1'b1, 1'b0, 3'd1, 1'b1, 4'd5}, // R5 untrusted
      '{32'h0000_0001, 8'hFF, 3'd7, 1'b0, 1'b0, 1'b1, 3'd1, 1'b0, 4'd5}, // R5 trusted
      '{32'h0040_0000, 8'hFF, 3'd2, 1'b0, 1'b1, 1'b0, 3'd5, 1'b0, 4'd6}, // R6 super+priv
      '{32'h0040_0000, 8'hFF, 3'd2, 1'b0, 1'b0, 1'b0, 3'd5, 1'b1, 4'd6}, // R6 no super
      '{32'h0040_0000, 8'hDF, 3'd2, 1'b0, 1'b1, 1'b0, 3'd5, 1'b1, 4'd6}, // R6 priv bit off
      '{32'h0040_0000, 8'hDF, 3'd2, 1'b1, 1'b1, 1'b0, 3'd4, 1'b0, 4'd11}, // R11 other master
      '{32'h2000_0000, 8'hFF, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 4'd2}, // R2 other slot
      '{32'h7777_7777, 8'h80, 3'd6, 1'b1, 1'b1, 1'b1, 3'd7, 1'b1, 4'd4}, // R4 all set, write
      '{32'h7777_7777, 8'h80, 3'd6, 1'b0, 1'b1, 1'b1, 3'd7, 1'b0, 4'd6}  // R6 all set, read
   };

   task automatic reg_write(input logic sel, input logic [31:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic sel, output logic [31:0] d);
      reg_sel = sel;
      #1;
      d = reg_rdata;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Issue one request; return outcome sampled in the following cycle.
   task automatic issue(input logic [2:0] slot, input logic wr, input logic sup,
                        input logic tru, input logic [2:0] mid,
                        output logic e, output logic d, output logic [2:0] s,
                        output logic w);
      @(negedge clk);
      req_valid = 1'b1; req_slot = slot; req_write = wr;
      req_super = sup; req_trusted = tru; req_mid = mid;
      @(negedge clk);
      req_valid = 1'b0;
      e = err_resp; d = dn_valid; s = dn_slot; w = dn_write;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL R8 watchdog actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic e, d, w;
      logic [2:0] s;

      repeat (3) @(negedge clk);
      // R1 reset values
      reg_read(1'b0, rd); check("R1 acr reset", rd, 32'h0);
      reg_read(1'b1, rd); check("R1 priv reset", rd, 32'h0000_00FF);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 idle after reset", {30'd0, dn_valid, err_resp}, 32'd0);

      // Vector table walk
      for (int i = 0; i < NV; i++) begin
         reg_write(1'b0, VECS[i].acr);
         reg_write(1'b1, {24'd0, VECS[i].priv});
         issue(VECS[i].slot, VECS[i].wr, VECS[i].sup, VECS[i].tru, VECS[i].mid, e, d, s, w);
         check($sformatf("R%0d vector %0d outcome", VECS[i].req, i),
               {30'd0, e, d}, {30'd0, VECS[i].exp_err, ~VECS[i].exp_err});
         if (!VECS[i].exp_err)
            check($sformatf("R9 vector %0d echo", i), {28'd0, s, w},
                  {28'd0, VECS[i].slot, VECS[i].wr});
         // R8: outcome lasts one cycle
         @(negedge clk);
         check("R8 single cycle pulse", {30'd0, err_resp, dn_valid}, 32'd0);
      end

      // R2: walk write-protect across slots; neighbour unaffected
      for (int k = 0; k < 8; k++) begin
         reg_write(1'b0, 32'h1 << (29 - 4*k));
         issue(3'(k), 1'b1, 1'b0, 1'b1, 3'd0, e, d, s, w);
         check($sformatf("R2 slot %0d protected", k), {30'd0, e, d}, 32'd2);
         issue(3'(k+1), 1'b1, 1'b0, 1'b1, 3'd0, e, d, s, w);
         check($sformatf("R2 slot %0d neighbour", k), {30'd0, e, d}, 32'd1);
      end

      // R3 reserved bits masked; priv upper bits zero
      reg_write(1'b0, 32'hFFFF_FFFF);
      reg_read(1'b0, rd); check("R3 reserved masked", rd, 32'h7777_7777);
      reg_write(1'b1, 32'hFFFF_FF5A);
      reg_read(1'b1, rd); check("R3 priv upper zero", rd, 32'h0000_005A);
      // R11 readback of privilege bits
      check("R11 priv readback", rd & 32'hFF, 32'h5A);

      // R10: write and request in the same cycle use the old value
      reg_write(1'b0, 32'h0);
      @(negedge clk);
      reg_sel = 1'b0; reg_wdata = 32'h2000_0000; reg_wr = 1'b1;
      req_valid = 1'b1; req_slot = 3'd0; req_write = 1'b1;
      req_super = 1'b0; req_trusted = 1'b1; req_mid = 3'd0;
      @(negedge clk);
      reg_wr = 1'b0; req_valid = 1'b0;
      check("R10 same-cycle old value", {30'd0, err_resp, dn_valid}, 32'd1);
      issue(3'd0, 1'b1, 1'b0, 1'b1, 3'd0, e, d, s, w);
      check("R10 next cycle new value", {30'd0, e, d}, 32'd2);

      // R7 open slot with every attribute low
      reg_write(1'b0, 32'h0);
      issue(3'd5, 1'b1, 1'b0, 1'b0, 3'd3, e, d, s, w);
      check("R7 open slot passes", {30'd0, e, d}, 32'd1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule